// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block collects per-source hardware interrupt events into a sticky cause register and presents them to software through a small word-addressed register bank. Software decides bit by bit how a pending cause is acknowledged: either by writing a one to it, or simply by reading it. A mask register hides sources from the interrupt line. It can be loaded as a whole, or changed one bit at a time through separate set and clear aliases, so no read-modify-write sequence is needed.

A masked view of the cause register shows only the unmasked pending sources. A write-only set register lets software inject an interrupt on any source. The single level interrupt output is high while any unmasked cause bit is pending. It is registered, so it follows the cause and mask state one cycle later. Bit position n refers to source n in every register.

Word offsets are: 0 cause control, 1 cause, 2 masked cause, 3 cause set, 4 mask value, 5 mask set, 6 mask clear. Offset 7, and any address with a bit set above bit 2, is unmapped.

Top module: `irqBank`

## Requirements
- R1: The cause-control register at offset 0 is fully readable and writable, and it reads back the last value written.
- R2: A one on hwEvent[n] in a cycle sets cause bit n at the next clock edge. The bit stays set until it is cleared.
- R3: When control bit n is 0, writing a 1 to bit n of the cause register (offset 1) clears cause bit n. Writing 0, or writing to a bit whose control bit is 1, leaves the cause unchanged.
- R4: When control bit n is 1, a bus read of the cause register returns the current cause and then clears bit n.
- R5: The masked-cause register (offset 2) reads as cause AND NOT mask. A write-one or a read through it clears only the bits it shows (unmasked bits), each by that bit's control rule.
- R6: Writing a 1 to bit n of the cause-set register (offset 3) sets cause bit n. This register always reads as 0.
- R7: The mask register at offset 4 is fully readable and writable. A 1 written to mask-set (offset 5) sets that mask bit, and a 1 written to mask-clear (offset 6) clears it. Zero bits in either write have no effect, and both aliases read as 0.
- R8: A hardware event in the same cycle as a write-one or read clear of the same bit wins, so the bit stays set.
- R9: Clear-on-read happens only on a read of offset 1 or 2. Reads of any other register, and reads of unmapped addresses (which return 0), leave the cause unchanged.
- R10: irqOut is the OR of all masked-cause bits, taken from the state one clock earlier.
- R11: After reset, cause and cause control are 0, every mask bit is 1, and irqOut is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Word address of the register |
| wrEn | input | 1 | Write strobe for the current cycle |
| rdEn | input | 1 | Read strobe for the current cycle |
| wrData | input | SRC_W | Write data |
| rdData | output | SRC_W | Read data, valid in the cycle rdEn is high |
| hwEvent | input | SRC_W | Per-source event pulses |
| irqOut | output | 1 | Level interrupt request |

## Verification
The bench builds the bank with SRC_W=16 and ADDR_W=4. Sixteen sources are enough to put write-one-clear, clear-on-read, masked and unmasked bits side by side in one word. The fourth address bit lets the bench issue a read whose low bits alias the cause register but which is unmapped, and so confirm that such a read neither returns data nor acknowledges anything. Same-cycle collisions between hardware events and both kinds of clear are driven on purpose.

// File: rtl/irqBankPkg.sv
package irqBankPkg;

  // Word offsets inside the bank; the order is the software-visible map.
  typedef enum logic [2:0] {
    OFS_CTL    = 3'd0,
    OFS_CAUSE  = 3'd1,
    OFS_MASKED = 3'd2,
    OFS_SET    = 3'd3,
    OFS_MASK   = 3'd4,
    OFS_MSET   = 3'd5,
    OFS_MCLR   = 3'd6
  } regOfsT;

  localparam int OFS_BITS = 3;

  // Strobes from the decoder to the register datapath.
  typedef struct packed {
    logic       wrCtl;
    logic       wrCause;
    logic       wrMasked;
    logic       wrSet;
    logic       wrMask;
    logic       wrMaskSet;
    logic       wrMaskClr;
    logic       rdCause;
    logic       rdMasked;
    logic       rdHit;
    logic [2:0] rdSel;
  } bankStrbT;

endpackage

// File: rtl/irqBankCtrl.sv
module irqBankCtrl
  import irqBankPkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output bankStrbT          strb
);

  localparam int HI_W = ADDR_W - OFS_BITS;

  logic       inRange;
  logic [2:0] ofs;

  assign ofs = addr[OFS_BITS-1:0];

  generate
    if (HI_W > 0) begin : g_hiDecode
      assign inRange = (addr[ADDR_W-1:OFS_BITS] == '0);
    end else begin : g_noHi
      assign inRange = 1'b1;
    end
  endgenerate

  logic wrHit;
  logic rdHitInt;
  assign wrHit    = wrEn && inRange;
  assign rdHitInt = rdEn && inRange;

  always_comb begin
    strb           = '0;
    strb.wrCtl     = wrHit && (ofs == OFS_CTL);
    strb.wrCause   = wrHit && (ofs == OFS_CAUSE);
    strb.wrMasked  = wrHit && (ofs == OFS_MASKED);
    strb.wrSet     = wrHit && (ofs == OFS_SET);
    strb.wrMask    = wrHit && (ofs == OFS_MASK);
    strb.wrMaskSet = wrHit && (ofs == OFS_MSET);
    strb.wrMaskClr = wrHit && (ofs == OFS_MCLR);
    strb.rdCause   = rdHitInt && (ofs == OFS_CAUSE);
    strb.rdMasked  = rdHitInt && (ofs == OFS_MASKED);
    strb.rdHit     = rdHitInt;
    strb.rdSel     = ofs;
  end

endmodule

// File: rtl/irqBankData.sv
module irqBankData
  import irqBankPkg::*;
#(
  parameter int SRC_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  bankStrbT         strb,
  input  logic [SRC_W-1:0] wrData,
  input  logic [SRC_W-1:0] hwEvent,
  output logic [SRC_W-1:0] rdData,
  output logic             irqOut
);

  logic [SRC_W-1:0] ctlQ, causeQ, maskQ;
  logic [SRC_W-1:0] maskedView;
  logic [SRC_W-1:0] w1cBits, corBits, swSet;
  logic [SRC_W-1:0] causeD, maskD;
  logic             irqQ;

  assign maskedView = causeQ & ~maskQ;

  // Write-one clear applies to bits whose control bit is 0; through the
  // masked view only the visible bits are reachable.
  always_comb begin
    w1cBits = '0;
    if (strb.wrCause)       w1cBits = wrData & ~ctlQ;
    else if (strb.wrMasked) w1cBits = wrData & ~ctlQ & ~maskQ;
  end

  // Clear-on-read applies to bits whose control bit is 1.
  always_comb begin
    corBits = '0;
    if (strb.rdCause)       corBits = ctlQ;
    else if (strb.rdMasked) corBits = ctlQ & ~maskQ;
  end

  assign swSet  = strb.wrSet ? wrData : '0;
  // Events and software sets are ORed after the clear, so they win.
  assign causeD = (causeQ & ~(w1cBits | corBits)) | swSet | hwEvent;

  always_comb begin
    maskD = maskQ;
    if (strb.wrMask)         maskD = wrData;
    else if (strb.wrMaskSet) maskD = maskQ | wrData;
    else if (strb.wrMaskClr) maskD = maskQ & ~wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ   <= '0;
      causeQ <= '0;
      maskQ  <= '1;
      irqQ   <= 1'b0;
    end else begin
      if (strb.wrCtl) ctlQ <= wrData;
      causeQ <= causeD;
      maskQ  <= maskD;
      irqQ   <= |maskedView;
    end
  end

  assign irqOut = irqQ;

  always_comb begin
    rdData = '0;
    if (strb.rdHit) begin
      case (strb.rdSel)
        OFS_CTL:    rdData = ctlQ;
        OFS_CAUSE:  rdData = causeQ;
        OFS_MASKED: rdData = maskedView;
        OFS_MASK:   rdData = maskQ;
        default:    rdData = '0;
      endcase
    end
  end

  // ---------------- assertions ----------------
  p_event_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hwEvent != '0) |=> ((causeQ & $past(hwEvent)) == $past(hwEvent)));

  p_event_latch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCause == 1'b0 && strb.wrMasked == 1'b0 && strb.rdCause == 1'b0
     && strb.rdMasked == 1'b0 && strb.wrSet == 1'b0)
    |=> (causeQ == ($past(causeQ) | $past(hwEvent))));

  p_sw_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSet |=> ((causeQ & $past(wrData)) == $past(wrData)));

  p_mask_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMaskSet |=> ((maskQ & $past(wrData)) == $past(wrData)));

  p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMaskClr |=> ((maskQ & $past(wrData)) == '0));

  p_cor_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdCause && hwEvent == '0) |=> ((causeQ & $past(ctlQ)) == '0));

  p_irq_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((causeQ & ~maskQ) == '0) |=> !irqOut);

  p_irq_high_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((causeQ & ~maskQ) != '0) |=> irqOut);

endmodule

// File: rtl/irqBank.sv
module irqBank
  import irqBankPkg::*;
#(
  parameter int SRC_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [SRC_W-1:0]  wrData,
  output logic [SRC_W-1:0]  rdData,
  input  logic [SRC_W-1:0]  hwEvent,
  output logic              irqOut
);

  bankStrbT strb;

  irqBankCtrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .addr (addr),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .strb (strb)
  );

  irqBankData #(.SRC_W(SRC_W)) i_data (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .hwEvent (hwEvent),
    .rdData  (rdData),
    .irqOut  (irqOut)
  );

  p_no_x_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(irqOut));

endmodule

// File: tb/test_irqBank.sv
module test_irqBank;

  localparam int SRC_W  = 16;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wrEn = 1'b0;
  logic              rdEn = 1'b0;
  logic [SRC_W-1:0]  wrData = '0;
  logic [SRC_W-1:0]  rdData;
  logic [SRC_W-1:0]  hwEvent = '0;
  logic              irqOut;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  logic [SRC_W-1:0] expQ[$];
  string            tagQ[$];

  always #10 clk = ~clk;  // 50 MHz

  irqBank #(.SRC_W(SRC_W), .ADDR_W(ADDR_W)) i_irqBank (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .hwEvent(hwEvent), .irqOut(irqOut)
  );

  // Monitor: compares read data in the low phase of the read cycle.
  always @(negedge clk) begin
    if (rdEn && expQ.size() > 0) begin
      logic [SRC_W-1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      total++;
      if (rdData !== e) begin
        bad++;
        $display("FAIL %s: rdData=%h expected=%h", t, rdData, e);
      end
    end
  end

  // One bus cycle: inputs change 2 ns after an edge, act at the next edge.
  task automatic busOp(input logic [ADDR_W-1:0] a, input bit wr, input bit rd,
                       input logic [SRC_W-1:0] d, input logic [SRC_W-1:0] hw,
                       input logic [SRC_W-1:0] exp, input string tag);
    @(posedge clk); #2;
    addr = a; wrEn = wr; rdEn = rd; wrData = d; hwEvent = hw;
    if (rd) begin
      expQ.push_back(exp);
      tagQ.push_back(tag);
    end
    @(posedge clk); #2;
    wrEn = 1'b0; rdEn = 1'b0; hwEvent = '0; wrData = '0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [SRC_W-1:0] d);
    busOp(a, 1'b1, 1'b0, d, '0, '0, "");
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [SRC_W-1:0] e,
                    input string tag);
    busOp(a, 1'b0, 1'b1, '0, '0, e, tag);
  endtask

  task automatic pulse(input logic [SRC_W-1:0] hw);
    busOp('0, 1'b0, 1'b0, '0, hw, '0, "");
  endtask

  task automatic checkIrq(input logic e, input string tag);
    @(posedge clk); #2;
    @(negedge clk);
    total++;
    if (irqOut !== e) begin
      bad++;
      $display("FAIL %s: irqOut=%b expected=%b", tag, irqOut, e);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    // R11 reset values
    rd(4'd0, 16'h0000, "R11 control after reset");
    rd(4'd1, 16'h0000, "R11 cause after reset");
    rd(4'd4, 16'hFFFF, "R11 mask after reset");
    checkIrq(1'b0, "R11 irq after reset");

    // R1 control readback, R7 direct mask write
    wr(4'd4, 16'h00F0);
    rd(4'd4, 16'h00F0, "R7 mask value readback");
    wr(4'd0, 16'h0F00);
    rd(4'd0, 16'h0F00, "R1 control readback");

    // R2 event latch, R5 masked view, R10 irq
    pulse(16'h0011);
    rd(4'd1, 16'h0011, "R2 events latched");
    rd(4'd2, 16'h0001, "R5 masked view");
    checkIrq(1'b1, "R10 irq with unmasked cause");

    // R3 write-one clear
    wr(4'd1, 16'h0001);
    rd(4'd1, 16'h0010, "R3 write one clears");
    wr(4'd1, 16'h0000);
    rd(4'd1, 16'h0010, "R3 write zero no effect");
    checkIrq(1'b0, "R10 irq drops when masked cause empty");

    // R6 software set
    wr(4'd3, 16'h0300);
    rd(4'd3, 16'h0000, "R6 set register reads zero");

    // R9 other reads do not clear; R4 clear on read
    rd(4'd0, 16'h0F00, "R9 control read");
    rd(4'd4, 16'h00F0, "R9 mask read");
    rd(4'd9, 16'h0000, "R9 unmapped read returns zero");
    rd(4'd1, 16'h0310, "R6 set bits visible, R9 nothing cleared");
    rd(4'd1, 16'h0010, "R4 read cleared control-one bits");

    // R3 write-one has no effect on a clear-on-read bit
    wr(4'd3, 16'h0100);
    wr(4'd1, 16'h0100);
    rd(4'd1, 16'h0110, "R3 write one ignored on read-clear bit");
    rd(4'd1, 16'h0010, "R4 read clear of bit 8");

    // R5 clear on read through masked view touches only visible bits
    wr(4'd3, 16'h0C00);
    wr(4'd5, 16'h0800);
    rd(4'd4, 16'h08F0, "R7 mask set");
    rd(4'd2, 16'h0400, "R5 masked read");
    rd(4'd1, 16'h0810, "R5 masked read cleared only visible bit");
    rd(4'd1, 16'h0010, "R4 cause read clears bit 11");

    // R7 mask clear and alias reads
    wr(4'd6, 16'h00F0);
    rd(4'd4, 16'h0800, "R7 mask clear");
    rd(4'd5, 16'h0000, "R7 mask set alias reads zero");
    rd(4'd6, 16'h0000, "R7 mask clear alias reads zero");

    // R5 write-one through masked view
    wr(4'd2, 16'h0010);
    rd(4'd1, 16'h0000, "R5 masked write one clears visible bit");
    pulse(16'h0002);
    wr(4'd5, 16'h0002);
    wr(4'd2, 16'h0002);
    rd(4'd1, 16'h0002, "R5 masked write ignores hidden bit");
    wr(4'd6, 16'h0002);
    wr(4'd2, 16'h0002);
    rd(4'd1, 16'h0000, "R5 masked write clears after unmask");

    // R8 event beats a same-cycle clear
    pulse(16'h0001);
    busOp(4'd1, 1'b1, 1'b0, 16'h0001, 16'h0001, '0, "");
    rd(4'd1, 16'h0001, "R8 event wins over write one clear");
    wr(4'd3, 16'h0100);
    busOp(4'd1, 1'b0, 1'b1, '0, 16'h0100, 16'h0101, "R8 read during event");
    rd(4'd1, 16'h0101, "R8 event wins over read clear");
    rd(4'd1, 16'h0001, "R4 later read clears bit 8");
    wr(4'd1, 16'h0001);
    rd(4'd1, 16'h0000, "R3 final clear");

    // R10 mask gates irq
    wr(4'd4, 16'hFFFF);
    pulse(16'h0001);
    checkIrq(1'b0, "R10 masked source keeps irq low");
    wr(4'd6, 16'h0001);
    checkIrq(1'b1, "R10 unmask raises irq");

    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule